// File: doc/BRIEF.md
# Serial ADC Control-Byte Framing Engine

This block is the digital side of an 8-channel, 10-bit serial converter that takes its conversion clock from the host's serial clock. With the chip select low, it watches the serial data input on every rising clock edge and waits for a start bit. It then collects the rest of an 8-bit control word: channel number, input polarity, input topology and power-down request. On the falling edge right after the last control bit, a conversion starts. The result comes back on the serial output, one bit per falling edge, most significant bit first, followed by two sub-bits and then zeros.

The analog core is not modelled here. A parallel result word and a 2-bit sub-bit word are sampled at the moment the conversion starts. The decoded control fields and the sampled result are latched at that same moment and shown on status outputs. A host can overlap the next control word with the tail of the current result, which allows one conversion every 15 serial clocks. Taking chip select high at any time drops the engine back to idle and releases the output.

Top module: `adc_serial_framer`

## Requirements
- R1: After reset, and whenever no start bit has been received, `dout` is 0 and no conversion starts. Pulling `cs_n` low with `din` low starts nothing.
- R2: While idle with `cs_n` low, the first rising edge on which `din` is 1 takes that bit as the start bit. Any zeros before it are ignored.
- R3: The control word arrives in this order: start (1), channel bits 2, 1, 0 (MSB first, plain binary), polarity (1 = unipolar), topology (1 = single-ended), power-down bit 1, power-down bit 0. These fields appear on `st_chan`, `st_unipolar`, `st_single` and `st_pd` from the conversion start onward.
- R4: A conversion starts on the falling edge that follows the rising edge which captured the eighth control bit. At that edge `result_in` and `sub_in` are sampled onto `st_result`, `dout` reads 0, and later changes to the inputs have no effect on the conversion.
- R5: On the next 12 falling edges, `dout` carries result bits 9 down to 0 and then sub-bits 1 and 0. After that it stays 0.
- R6: A 1 on `din` during a conversion, before result bit 3 has been driven on `dout`, is ignored. The conversion and its output continue unchanged.
- R7: Once result bit 3 has been driven, a 1 on `din` at any later rising edge is a new start bit. The remaining bits of the old result still shift out. Conversions can therefore begin every 15 clocks, or every 16.
- R8: `dout_en` is the inverse of `cs_n`. A rising edge with `cs_n` high returns the engine to idle, and a falling edge with `cs_n` high clears the pending output. A start bit after `cs_n` goes low again therefore aborts the earlier conversion.
- R9: With `cs_n` held low, 16 consecutive zeros on `din`, whatever came before them, are enough for the next 1 to be taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock. `din` is sampled on the rising edge and `dout` is driven on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial control data |
| result_in | input | 10 | Parallel conversion result, sampled at conversion start |
| sub_in | input | 2 | Sub-bits appended after the result |
| dout | output | 1 | Serial result data |
| dout_en | output | 1 | Output enable. Low means the output is released |
| st_chan | output | 3 | Latched channel number |
| st_unipolar | output | 1 | Latched polarity bit |
| st_single | output | 1 | Latched single-ended bit |
| st_pd | output | 2 | Latched power-down bits |
| st_result | output | 10 | Latched result word |

## Verification
The bench targets the edge of the start-acceptance window. It drives ones during the first seven clocks of a conversion, which a design with an early window would treat as a new start, and it runs back-to-back 15-clock frames, which a design with a late window would fail to follow. It changes `result_in` while a result is shifting out, to catch a design that does not latch the value. It toggles chip select in the middle of a conversion, to catch one that keeps shifting stale bits. It also sends random bit streams followed by 16 zeros and a control word, which a design that loses frame alignment would decode as the wrong channel.

// File: rtl/adc_frm_pkg.sv
// Shared constants and types for the serial ADC framing engine.
// Assumes a fixed 8-bit control word with the start bit arriving first.
package adc_frm_pkg;

    // Control word length and field positions (bit 7 is the start bit)
    localparam int CTRL_W   = 8;
    localparam int CHAN_W   = 3;
    localparam int CHAN_MSB = CTRL_W - 2;
    localparam int UNI_BIT  = 3;
    localparam int SGL_BIT  = 2;
    localparam int PD_W     = 2;

    // Framer states on the rising-edge side
    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_CTRL = 2'd1,
        FR_CONV = 2'd2
    } frm_state_e;

endpackage

// File: rtl/adc_ctrl_capture.sv
// Rising-edge half of the framer: finds the start bit, shifts in the
// control word and counts clocks within the conversion to decide when
// a new start bit may be accepted.
// Assumes cs_n and din are stable around the rising edge of sclk.
module adc_ctrl_capture
    import adc_frm_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int LATE_BIT = 3
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              din,
    output logic              conv_start,
    output logic [CTRL_W-1:0] ctrl_byte
);

    // Rising edges counted in FR_CONV before result bit LATE_BIT has been driven
    localparam int ACC     = RES_W - LATE_BIT;
    localparam int CNT_MAX = (ACC > CTRL_W) ? ACC : CTRL_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ACC_C  = CNT_W'(ACC);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(CTRL_W - 1);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    frm_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              late_ok;

    // Start bits are welcome again once the late result bit is out
    assign late_ok = (cnt_q >= ACC_C);

    // Framing state machine: start hunt, control shift and conversion count
    always_ff @(posedge sclk) begin
        if (!rst_n) begin
            state_q <= FR_IDLE;
            cnt_q   <= '0;
            ctrl_q  <= '0;
        end else if (cs_n) begin
            state_q <= FR_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                FR_IDLE: begin
                    if (din) begin
                        state_q <= FR_CTRL;
                        cnt_q   <= ONE_C;
                        ctrl_q  <= CTRL_W'(1);
                    end
                end
                FR_CTRL: begin
                    ctrl_q <= {ctrl_q[CTRL_W-2:0], din};
                    if (cnt_q == LAST_C) begin
                        state_q <= FR_CONV;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + ONE_C;
                    end
                end
                FR_CONV: begin
                    if (late_ok) begin
                        if (din) begin
                            state_q <= FR_CTRL;
                            cnt_q   <= ONE_C;
                            ctrl_q  <= CTRL_W'(1);
                        end
                    end else begin
                        cnt_q <= cnt_q + ONE_C;
                    end
                end
                default: state_q <= FR_IDLE;
            endcase
        end
    end

    // Conversion start window: first half-cycle after the last control bit
    assign conv_start = (state_q == FR_CONV) && (cnt_q == '0);
    assign ctrl_byte  = ctrl_q;

    // R6: a high din before the late bit must not leave the conversion
    p_no_early_start_r6: assert property (@(posedge sclk) disable iff (!rst_n)
        (state_q == FR_CONV && cnt_q < ACC_C && !cs_n) |=> (state_q == FR_CONV));

    // R8: chip select high forces idle on the next edge
    p_cs_idle_r8: assert property (@(posedge sclk) disable iff (!rst_n)
        cs_n |=> (state_q == FR_IDLE && !conv_start));

    // R4: the conversion start is a single-cycle event
    p_start_pulse_r4: assert property (@(posedge sclk) disable iff (!rst_n)
        conv_start |=> !conv_start);

endmodule

// File: rtl/adc_result_shifter.sv
// Falling-edge half of the framer: latches the result and control fields
// at conversion start and shifts the result, then the sub-bits, out on dout.
// Assumes conv_start and ctrl_byte come from rising-edge logic on sclk.
module adc_result_shifter
    import adc_frm_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int SUB_W = 2
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              conv_start,
    input  logic [CTRL_W-1:0] ctrl_byte,
    input  logic [RES_W-1:0]  result_in,
    input  logic [SUB_W-1:0]  sub_in,
    output logic              dout,
    output logic [CHAN_W-1:0] st_chan,
    output logic              st_unipolar,
    output logic              st_single,
    output logic [PD_W-1:0]   st_pd,
    output logic [RES_W-1:0]  st_result
);

    localparam int W = RES_W + SUB_W;

    logic [W-1:0] sh_q;
    logic         dout_q;

    // Output shifter: load at conversion start, then one bit per falling edge
    always_ff @(negedge sclk) begin
        if (!rst_n || cs_n) begin
            sh_q   <= '0;
            dout_q <= 1'b0;
        end else if (conv_start) begin
            sh_q   <= {result_in, sub_in};
            dout_q <= 1'b0;
        end else begin
            dout_q <= sh_q[W-1];
            sh_q   <= {sh_q[W-2:0], 1'b0};
        end
    end

    // Status latch: decoded fields and result captured at conversion start
    always_ff @(negedge sclk) begin
        if (!rst_n) begin
            st_chan     <= '0;
            st_unipolar <= 1'b0;
            st_single   <= 1'b0;
            st_pd       <= '0;
            st_result   <= '0;
        end else if (conv_start && !cs_n) begin
            st_chan     <= ctrl_byte[CHAN_MSB -: CHAN_W];
            st_unipolar <= ctrl_byte[UNI_BIT];
            st_single   <= ctrl_byte[SGL_BIT];
            st_pd       <= ctrl_byte[PD_W-1:0];
            st_result   <= result_in;
        end
    end

    assign dout = dout_q;

    // R4: the latched result equals the input seen at the start edge
    p_latch_result_r4: assert property (@(negedge sclk) disable iff (!rst_n)
        (conv_start && !cs_n) |=> (st_result == $past(result_in)));

    // R5: once every bit has left the shifter, the line stays low
    p_zero_fill_r5: assert property (@(negedge sclk) disable iff (!rst_n)
        (sh_q == '0 && !conv_start) |=> (dout == 1'b0));

endmodule

// File: rtl/adc_serial_framer.sv
// Top of the serial ADC framing engine. It joins the rising-edge
// control capture and the falling-edge result shifter, and exposes
// the output enable and the latched status fields.
// Assumes sclk is the only clock and rst_n is synchronous to it.
module adc_serial_framer
    import adc_frm_pkg::*;
#(
    parameter int RES_W    = 10,
    parameter int SUB_W    = 2,
    parameter int LATE_BIT = 3
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             din,
    input  logic [RES_W-1:0] result_in,
    input  logic [SUB_W-1:0] sub_in,
    output logic             dout,
    output logic             dout_en,
    output logic [2:0]       st_chan,
    output logic             st_unipolar,
    output logic             st_single,
    output logic [1:0]       st_pd,
    output logic [RES_W-1:0] st_result
);

    logic              conv_start;
    logic [CTRL_W-1:0] ctrl_byte;

    // Start hunt and control word capture
    adc_ctrl_capture #(
        .RES_W    (RES_W),
        .LATE_BIT (LATE_BIT)
    ) u_capture (
        .sclk       (sclk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .din        (din),
        .conv_start (conv_start),
        .ctrl_byte  (ctrl_byte)
    );

    // Result latch and serial output
    adc_result_shifter #(
        .RES_W (RES_W),
        .SUB_W (SUB_W)
    ) u_shifter (
        .sclk        (sclk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .conv_start  (conv_start),
        .ctrl_byte   (ctrl_byte),
        .result_in   (result_in),
        .sub_in      (sub_in),
        .dout        (dout),
        .st_chan     (st_chan),
        .st_unipolar (st_unipolar),
        .st_single   (st_single),
        .st_pd       (st_pd),
        .st_result   (st_result)
    );

    // Output released whenever the chip is deselected
    assign dout_en = !cs_n;

endmodule

// File: tb/test_adc_serial_framer.sv
// Bench for adc_serial_framer: directed frames and seeded random streams,
// compared each clock against a bench model built from the requirements.
module test_adc_serial_framer;

    logic       sclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       din = 1'b0;
    logic [9:0] result_in = '0;
    logic [1:0] sub_in = '0;
    logic       dout, dout_en, st_unipolar, st_single;
    logic [2:0] st_chan;
    logic [1:0] st_pd;
    logic [9:0] st_result;

    int checks = 0;
    int fails  = 0;

    // Bench model state
    bit         m_act = 0;
    int         m_k = 0;
    int         m_oi = 12;
    logic [11:0] m_word = '0;
    logic [7:0] m_ctrl = '0;
    bit         m_load = 0;
    logic       m_exp = 0;

    always #2.5 sclk = ~sclk;

    adc_serial_framer i_adc_serial_framer (
        .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .din(din),
        .result_in(result_in), .sub_in(sub_in),
        .dout(dout), .dout_en(dout_en), .st_chan(st_chan),
        .st_unipolar(st_unipolar), .st_single(st_single),
        .st_pd(st_pd), .st_result(st_result)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Model of one rising edge, from R2, R3, R6, R7, R8
    function automatic void model_rise(input logic d, input logic c);
        if (c) m_act = 0;
        else if ((!m_act || m_k >= 14) && d) begin
            m_act = 1; m_k = 0; m_ctrl = 8'h01;
        end else if (m_act) begin
            if (m_k < 7) m_ctrl = {m_ctrl[6:0], d};
            if (m_k < 50) m_k++;
        end
    endfunction

    // Model of one falling edge, from R4, R5, R8
    function automatic void model_fall(input logic c);
        m_load = 0;
        if (c) begin
            m_oi = 12; m_exp = 0;
        end else if (m_act && m_k == 7) begin
            m_load = 1; m_word = {result_in, sub_in}; m_oi = 0; m_exp = 0;
        end else if (m_oi < 12) begin
            m_exp = m_word[11 - m_oi]; m_oi++;
        end else m_exp = 0;
    endfunction

    // One serial clock: drive, model both edges, sample after the falling edge
    task automatic tick(input logic d, input logic c, input string tag);
        din = d; cs_n = c;
        @(posedge sclk);
        model_rise(d, c);
        @(negedge sclk);
        model_fall(c);
        #1;
        chk(dout === m_exp, tag, "dout", int'(dout), int'(m_exp));
        chk(dout_en === !c, "R8", "dout_en", int'(dout_en), int'(!c));
        if (m_load) begin
            chk(st_chan === m_ctrl[6:4], "R3", "st_chan", int'(st_chan), int'(m_ctrl[6:4]));
            chk(st_unipolar === m_ctrl[3], "R3", "st_unipolar", int'(st_unipolar), int'(m_ctrl[3]));
            chk(st_single === m_ctrl[2], "R3", "st_single", int'(st_single), int'(m_ctrl[2]));
            chk(st_pd === m_ctrl[1:0], "R3", "st_pd", int'(st_pd), int'(m_ctrl[1:0]));
            chk(st_result === m_word[11:2], "R4", "st_result", int'(st_result), int'(m_word[11:2]));
        end
    endtask

    task automatic send_ctrl(input logic [2:0] ch, input logic uni, input logic sgl,
                             input logic [1:0] pd, input string tag);
        logic [7:0] b;
        b = {1'b1, ch, uni, sgl, pd};
        for (int i = 7; i >= 0; i--) tick(b[i], 1'b0, tag);
    endtask

    task automatic zeros(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, tag);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge sclk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge sclk);
        @(negedge sclk); #1;
        rst_n = 1'b1;
        chk(dout === 1'b0, "R1", "reset dout", int'(dout), 0);
        chk(dout_en === 1'b0, "R1", "reset dout_en", int'(dout_en), 0);

        // R1/R2: chip select low with zeros, then a start bit
        zeros(6, "R1");
        result_in = 10'h2B5; sub_in = 2'b10;
        send_ctrl(3'd5, 1'b1, 1'b0, 2'b11, "R2");
        chk(st_chan === 3'd5, "R2", "chan after leading zeros", int'(st_chan), 5);
        // R4: inputs change while the result shifts out
        for (int i = 0; i < 14; i++) begin
            result_in = 10'($urandom); sub_in = 2'($urandom);
            tick(1'b0, 1'b0, "R4");
        end
        zeros(4, "R5");

        // R6: ones before the late result bit are ignored
        result_in = 10'h1C3; sub_in = 2'b01;
        send_ctrl(3'd2, 1'b0, 1'b1, 2'b00, "R6");
        for (int i = 0; i < 7; i++) tick(1'b1, 1'b0, "R6");
        zeros(10, "R6");
        chk(st_result === 10'h1C3, "R6", "result kept", int'(st_result), 'h1C3);

        // R7: back-to-back 15-clock and 16-clock frames
        for (int f = 0; f < 6; f++) begin
            result_in = 10'($urandom); sub_in = 2'($urandom);
            send_ctrl(3'(f), 1'(f), 1'(f >> 1), 2'(f), "R7");
            zeros((f < 3) ? 7 : 8, "R7");
        end
        zeros(14, "R5");

        // R8: deselect mid-conversion, then a fresh start
        result_in = 10'h3FF; sub_in = 2'b11;
        send_ctrl(3'd7, 1'b1, 1'b1, 2'b01, "R8");
        zeros(3, "R8");
        tick(1'b1, 1'b1, "R8");
        result_in = 10'h001; sub_in = 2'b00;
        send_ctrl(3'd1, 1'b0, 1'b0, 2'b10, "R8");
        chk(st_chan === 3'd1, "R8", "chan after abort", int'(st_chan), 1);
        zeros(16, "R8");

        // R9: random garbage, 16 zeros, then a control word
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < 37; i++) tick(1'($urandom % 2), 1'b0, "R9");
            zeros(16, "R9");
            result_in = 10'($urandom); sub_in = 2'($urandom);
            send_ctrl(3'd6, 1'b1, 1'b0, 2'b01, "R9");
            chk(st_chan === 3'd6, "R9", "chan after flush", int'(st_chan), 6);
        end

        // Random mix of streams, deselects and results
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 5 == 0) begin
                result_in = 10'($urandom); sub_in = 2'($urandom);
            end
            tick(1'($urandom % 4 == 0), 1'($urandom % 100 == 0), "R5");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule